// File: doc/BRIEF.md
# Frame-Sync Activity Power Controller

This block decides whether a PCM codec core is powered up or powered down. It never reads a power register. It infers demand from activity: a rising edge on the transmit or receive frame sync wakes the core. A stretch with no such edge for a configurable number of system clock cycles puts it back to sleep. A dedicated power-off control input overrides everything while it is held high. When that input toggles like a clock, it counts as "enable".

The block drives two registered status flags and two gating signals. The status flags are `powered_up_o` and `tx_output_allowed_o`. The gating signals are a high-impedance enable for the serial data output and a power-down for the analog outputs. After a wake-up, the serial data output stays high-impedance until the second transmit frame sync. This gives the encoder one full frame to produce valid data. Everything runs in one system clock domain, and the frame-sync inputs arrive already synchronized. There is no data stream through this block, so every pin is plain control or status.

Top module: `fs_power_ctrl`

## Requirements
- R1: While reset is active and right after it, the block is powered down: `powered_up_o`=0, `tx_output_allowed_o`=0, `dout_hiz_o`=1, `analog_pd_o`=1.
- R2: When `pwr_off_i` has been sampled high on HOLD_CYCLES consecutive clock edges, the block is powered down one edge later. It stays down while `pwr_off_i` remains high, even if frame syncs arrive.
- R3: A `pwr_off_i` that toggles and is never high for HOLD_CYCLES consecutive edges does not block power-up.
- R4: From power-down, a sampled rising edge (previous sample 0, current 1) on `tx_fs_i` or `rx_fs_i` sets `powered_up_o` on that same clock edge. A sync input that is simply held high produces no further edges.
- R5: When powered up, if IDLE_CYCLES+1 clock edges pass after the last frame-sync rising edge with no new rising edge, the block powers down on the last of them. It is still up one edge earlier.
- R6: Every frame-sync rising edge while powered up restarts the idle count.
- R7: `tx_output_allowed_o` becomes 1 on the edge that samples the second `tx_fs_i` rising edge counted since power-up. The rising edge that caused the wake-up counts. Receive-sync edges never count.
- R8: The transmit-sync count clears on every power-down, so after a new wake-up two transmit rising edges are needed again.
- R9: `dout_hiz_o` is the inverse of `tx_output_allowed_o` and `analog_pd_o` is the inverse of `powered_up_o`. `tx_output_allowed_o` is never 1 while `powered_up_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_off_i | input | 1 | Power-off control; static high forces power-down, low or toggling enables |
| tx_fs_i | input | 1 | Transmit frame sync, pre-synchronized |
| rx_fs_i | input | 1 | Receive frame sync, pre-synchronized |
| powered_up_o | output | 1 | Registered powered-up status |
| tx_output_allowed_o | output | 1 | Registered flag: serial data output may drive |
| dout_hiz_o | output | 1 | High-impedance enable for the serial data output |
| analog_pd_o | output | 1 | Power-down for the analog outputs |

## Verification
The assertions check the following on every cycle:
- data output permission implies power;
- a static-high control input that has reached its hold count brings power-down on the next edge;
- every wake-up and every data-output opening follows a sampled sync;
- every power-down closes the data output.

The idle timeout needs the bench's scenarios: its exact expiry edge and its restart by repeated syncs. So do the tolerance of a toggling control input, the count of two transmit syncs and its clearing across a sleep. The bench checks these with directed sequences. It also checks them with a long random run compared cycle by cycle against a bench-computed model.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
  typedef enum logic {
    PWR_DOWN = 1'b0,
    PWR_UP   = 1'b1
  } pwr_state_e;

  localparam int unsigned SYNC_TX  = 0;
  localparam int unsigned SYNC_RX  = 1;
  localparam int unsigned NUM_SYNC = 2;

  // transmit-sync counter: 0, 1, then saturates at 2 (output open)
  typedef logic [1:0] txcnt_t;
  localparam txcnt_t TX_OPEN = 2'd2;
endpackage

// File: rtl/fsp_edge_det.sv
module fsp_edge_det #(
  parameter int unsigned LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] lvl_i,
  output logic [LANES-1:0] rise_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl_i[g];
    end
    assign rise_o[g] = lvl_i[g] & ~prev_q;
  end
endmodule

// File: rtl/fsp_ctl_filter.sv
module fsp_ctl_filter #(
  parameter int unsigned HOLD_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_i,
  output logic force_off_o
);
  localparam int unsigned CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(HOLD_CYCLES);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            run_q <= '0;
    else if (!ctl_i)       run_q <= '0;
    else if (run_q != LIMIT) run_q <= run_q + 1'b1;
  end

  assign force_off_o = (run_q == LIMIT);
endmodule

// File: rtl/fsp_idle_timer.sv
module fsp_idle_timer #(
  parameter int unsigned IDLE_CYCLES = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic restart_i,
  output logic expired_o
);
  localparam int unsigned CW = $clog2(IDLE_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(IDLE_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (!run_i || restart_i) cnt_q <= '0;
    else if (cnt_q != LIMIT)    cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q == LIMIT);
endmodule

// File: rtl/fsp_state.sv
module fsp_state
  import fsp_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                force_off_i,
  input  logic [NUM_SYNC-1:0] rise_i,
  input  logic                expired_i,
  output logic                up_o,
  output logic                tx_open_o
);
  pwr_state_e state_q, state_d;
  txcnt_t     txc_q, txc_d;
  logic       any_rise;

  assign any_rise = |rise_i;

  always_comb begin
    state_d = state_q;
    if (force_off_i)              state_d = PWR_DOWN;
    else if (state_q == PWR_DOWN) state_d = any_rise ? PWR_UP : PWR_DOWN;
    else if (expired_i && !any_rise) state_d = PWR_DOWN;
  end

  always_comb begin
    txc_d = txc_q;
    if (state_d == PWR_DOWN)                      txc_d = '0;
    else if (rise_i[SYNC_TX] && txc_q != TX_OPEN) txc_d = txc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PWR_DOWN;
      txc_q   <= '0;
    end else begin
      state_q <= state_d;
      txc_q   <= txc_d;
    end
  end

  assign up_o      = (state_q == PWR_UP);
  assign tx_open_o = (txc_q == TX_OPEN);
endmodule

// File: rtl/fs_power_ctrl.sv
module fs_power_ctrl
  import fsp_pkg::*;
#(
  parameter int unsigned IDLE_CYCLES = 4096,
  parameter int unsigned HOLD_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_off_i,
  input  logic tx_fs_i,
  input  logic rx_fs_i,
  output logic powered_up_o,
  output logic tx_output_allowed_o,
  output logic dout_hiz_o,
  output logic analog_pd_o
);
  logic [NUM_SYNC-1:0] sync_lvl, sync_rise;
  logic force_off, expired, up, tx_open;

  assign sync_lvl[SYNC_TX] = tx_fs_i;
  assign sync_lvl[SYNC_RX] = rx_fs_i;

  fsp_edge_det #(.LANES(NUM_SYNC)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i(sync_lvl), .rise_o(sync_rise)
  );

  fsp_ctl_filter #(.HOLD_CYCLES(HOLD_CYCLES)) u_ctl (
    .clk(clk), .rst_n(rst_n), .ctl_i(pwr_off_i), .force_off_o(force_off)
  );

  fsp_idle_timer #(.IDLE_CYCLES(IDLE_CYCLES)) u_idle (
    .clk(clk), .rst_n(rst_n), .run_i(up), .restart_i(|sync_rise),
    .expired_o(expired)
  );

  fsp_state u_fsm (
    .clk(clk), .rst_n(rst_n), .force_off_i(force_off), .rise_i(sync_rise),
    .expired_i(expired), .up_o(up), .tx_open_o(tx_open)
  );

  assign powered_up_o        = up;
  assign tx_output_allowed_o = tx_open;
  assign dout_hiz_o          = ~tx_open;
  assign analog_pd_o         = ~up;
endmodule

// File: rtl/fsp_checker.sv
module fsp_checker #(
  parameter int unsigned HOLD_CYCLES = 8
) (
  input logic clk,
  input logic rst_n,
  input logic pwr_off_i,
  input logic tx_fs_i,
  input logic rx_fs_i,
  input logic powered_up_o,
  input logic tx_output_allowed_o
);
  localparam int unsigned CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(HOLD_CYCLES);

  logic [CW-1:0] hi_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               hi_run <= '0;
    else if (!pwr_off_i)      hi_run <= '0;
    else if (hi_run != LIMIT) hi_run <= hi_run + 1'b1;
  end

  assert_open_needs_power_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_output_allowed_o |-> powered_up_o);

  assert_forced_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_run == LIMIT) |=> !powered_up_o);

  assert_wake_on_sync_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(powered_up_o) |-> ($past(tx_fs_i) || $past(rx_fs_i)));

  assert_close_on_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(powered_up_o) |-> !tx_output_allowed_o);

  assert_open_on_tx_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_output_allowed_o) |-> $past(tx_fs_i));
endmodule

bind fs_power_ctrl fsp_checker #(.HOLD_CYCLES(HOLD_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_off_i(pwr_off_i), .tx_fs_i(tx_fs_i),
  .rx_fs_i(rx_fs_i), .powered_up_o(powered_up_o),
  .tx_output_allowed_o(tx_output_allowed_o)
);

// File: tb/sim_fs_power_ctrl.sv
module sim_fs_power_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int IDLE = 40;
  localparam int HOLD = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pwr_off = 1'b0, tx_fs = 1'b0, rx_fs = 1'b0;
  logic up, txok, hiz, apd;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fs_power_ctrl #(.IDLE_CYCLES(IDLE), .HOLD_CYCLES(HOLD)) u0 (
    .clk(clk), .rst_n(rst_n), .pwr_off_i(pwr_off), .tx_fs_i(tx_fs),
    .rx_fs_i(rx_fs), .powered_up_o(up), .tx_output_allowed_o(txok),
    .dout_hiz_o(hiz), .analog_pd_o(apd)
  );

  // reference model built from R2..R8, advanced on each clock edge
  logic m_ptx = 0, m_prx = 0, m_up = 0;
  int m_hi = 0, m_idle = 0, m_txc = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ptx = 0; m_prx = 0; m_up = 0; m_hi = 0; m_idle = 0; m_txc = 0;
    end else begin
      logic rt, rr, frc, exp_i, nup;
      rt = tx_fs && !m_ptx;
      rr = rx_fs && !m_prx;
      frc = (m_hi == HOLD);
      exp_i = (m_idle == IDLE);
      if (frc) nup = 0;
      else if (!m_up) nup = rt || rr;
      else nup = !(exp_i && !(rt || rr));
      if (!m_up || rt || rr) m_idle = 0;
      else if (m_idle < IDLE) m_idle++;
      if (!nup) m_txc = 0;
      else if (rt && m_txc < 2) m_txc++;
      m_hi = pwr_off ? ((m_hi < HOLD) ? m_hi + 1 : HOLD) : 0;
      m_up = nup; m_ptx = tx_fs; m_prx = rx_fs;
    end
  end

  function automatic logic exp_open(int c);
    return c >= 2;
  endfunction

  task automatic chk(string req, logic act, logic expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, expv, $time);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic model_cmp();
    chk("R4/R5/R6 model up", up, m_up);
    chk("R7/R8 model open", txok, exp_open(m_txc));
    chk("R9 hiz", hiz, !exp_open(m_txc));
    chk("R9 analog pd", apd, !m_up);
  endtask

  task automatic pulse_tx();
    tx_fs = 1; step(1); tx_fs = 0;
  endtask
  task automatic pulse_rx();
    rx_fs = 1; step(1); rx_fs = 0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    step(3);
    chk("R1 up", up, 1'b0); chk("R1 open", txok, 1'b0);
    chk("R1 hiz", hiz, 1'b1); chk("R1 apd", apd, 1'b1);
    rst_n = 1; step(2);
    chk("R1 after reset up", up, 1'b0);

    // R4 wake on tx, R7 count
    pulse_tx();
    chk("R4 wake on tx edge", up, 1'b1);
    chk("R7 closed after first tx", txok, 1'b0);
    step(2); pulse_rx();
    chk("R7 rx does not count", txok, 1'b0);
    step(2); pulse_tx();
    chk("R7 open after second tx", txok, 1'b1);
    chk("R9 hiz inverse", hiz, 1'b0);

    // R5 timeout with tx held high (R4 level gives no edge)
    step(1); tx_fs = 1; step(1);
    step(IDLE);
    chk("R5 still up one edge before expiry", up, 1'b1);
    step(1);
    chk("R5 down after idle", up, 1'b0);
    chk("R8 open cleared", txok, 1'b0);
    chk("R9 analog pd", apd, 1'b1);
    step(3);
    chk("R4 held sync does not wake", up, 1'b0);
    tx_fs = 0; step(2);

    // R8 re-wake needs two tx edges
    pulse_rx();
    chk("R4 wake on rx edge", up, 1'b1);
    step(1); pulse_tx();
    chk("R8 one tx after rewake stays closed", txok, 1'b0);
    step(1); pulse_tx();
    chk("R8 second tx opens", txok, 1'b1);

    // R6 restart
    for (int i = 0; i < 3; i++) begin
      step(IDLE - 5); pulse_rx();
    end
    chk("R6 kept alive by syncs", up, 1'b1);
    step(IDLE + 2);
    chk("R6 down after last restart", up, 1'b0);

    // R2 forced off
    pulse_tx();
    chk("R2 setup up", up, 1'b1);
    pwr_off = 1; step(HOLD);
    chk("R2 still up before hold reached", up, 1'b1);
    step(1);
    chk("R2 forced down", up, 1'b0);
    pulse_tx(); step(1);
    chk("R2 sync ignored while forced", up, 1'b0);
    pulse_rx();
    chk("R2 rx ignored while forced", up, 1'b0);
    pwr_off = 0; step(2);

    // R3 toggling control
    for (int i = 0; i < 10; i++) begin
      pwr_off = ~pwr_off;
      if (i == 5) tx_fs = 1; else tx_fs = 0;
      step(1);
    end
    chk("R3 toggling control allows wake", up, 1'b1);
    pwr_off = 0; tx_fs = 0; step(1);

    // random phase against model
    begin
      int mode = 0;
      for (int c = 0; c < 3000; c++) begin
        if (c % 60 == 0) mode = $urandom_range(0, 3);
        case (mode)
          0: pwr_off = 0;
          1: pwr_off = $urandom_range(0, 1);
          2: pwr_off = 1;
          default: pwr_off = 0;
        endcase
        if (mode == 3) begin
          tx_fs = 0; rx_fs = 0;
        end else begin
          tx_fs = ($urandom_range(0, 11) == 0);
          rx_fs = ($urandom_range(0, 13) == 0);
        end
        step(1);
        model_cmp();
      end
    end
    finish_run();
  end
endmodule